// File: doc/BRIEF.md
# Parallel EEPROM Write Capture Unit

This block sits on the device side of a byte-wide parallel EEPROM port. The chip-select, write-enable and output-enable strobes are all active low and arrive with no fixed relation to the internal clock. The block brings them into the clock domain. It delays the address and data buses through the same number of register stages, so that every strobe sample is seen next to the bus value that was present when it was taken. A write pulse exists while both select and write enable are low and output enable is high. The address is taken when the pulse begins, which is the moment the later of the two strobes falls. The data byte is taken when the pulse ends, which is the moment the earlier of the two strobes rises.

The block groups successive writes into a page with a retriggerable window timer. The first accepted write opens the window and fixes the page-select field, which is the top address bits. Every further write restarts the window. When the window runs out, the block gives a one-cycle commit strobe and then holds a busy flag for a fixed programming time. During that time every write pulse is ignored. Each accepted write appears once on the capture outputs as an address/data pair, ready for a page buffer.

Top module: `eeprom_write_capture`

## Requirements
- R1: After reset, `busy`, `commit`, `cap_valid` and `page_err` are all 0.
- R2: A write pulse exists only while `chip_sel_n`=0, `wr_en_n`=0 and `out_en_n`=1. A strobe pair with `out_en_n`=0 produces no capture and opens no page window.
- R3: The captured address is the `bus_addr` value present when the later of `chip_sel_n` and `wr_en_n` falls. Later changes of `bus_addr` during the pulse do not alter it.
- R4: The captured data is the `bus_data` value present when the earlier of `chip_sel_n` and `wr_en_n` rises. Earlier values during the pulse do not alter it.
- R5: Each accepted write gives exactly one `cap_valid` pulse, one cycle long, which carries its address and data.
- R6: The window restarts on every accepted pulse start and on every falling `wr_en_n` edge while a page is open. With SYNC_STAGES=2, `commit` is first seen WINDOW_CYC+SYNC_STAGES+1 clock cycles after the clock interval in which the restarting strobe fell.
- R7: On window expiry, `commit` is high for exactly one cycle, in the first cycle of `busy`. `busy` then stays high for exactly PROG_CYC cycles.
- R8: A write pulse that starts while `busy` is high gives no capture and no `page_err`.
- R9: The page select is `bus_addr[ADDR_W-1 -: PAGE_SEL_W]` (the top 2 bits by default). A pulse in an open window whose select differs from the page's select raises `page_err` for one cycle and is not captured.
- R10: The window does not expire while an accepted pulse is still low. Expiry then follows 2 cycles after the pulse end is seen, which is SYNC_STAGES+2 cycles after the strobe rises.
- R11: A write accepted while no page is open opens the window and sets the page select from its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel_n | input | 1 | Active-low select strobe, asynchronous |
| wr_en_n | input | 1 | Active-low write strobe, asynchronous |
| out_en_n | input | 1 | Active-low read enable; must be high for a write |
| bus_addr | input | ADDR_W | Byte address bus |
| bus_data | input | DATA_W | Data byte bus |
| cap_valid | output | 1 | One-cycle strobe for a captured write |
| cap_addr | output | ADDR_W | Captured address |
| cap_data | output | DATA_W | Captured data byte |
| page_err | output | 1 | One-cycle flag for a rejected write with a mismatched page select |
| commit | output | 1 | One-cycle page commit strobe |
| busy | output | 1 | Programming period in progress |

## Verification
The assertions assume that the strobes behave like a real host bus. Each strobe level is held for several clocks, so a pulse start and a pulse end never come in adjacent cycles. The buses are assumed stable for at least one clock after the strobe edge at which they are sampled. The bench drives every input on the falling clock edge and holds each strobe level for two or more cycles. It changes address and data in the middle of a pulse and again one cycle after the last strobe rises. The ignored writes are placed fully inside the busy period, and the page-mismatch writes are placed inside an open window.

// File: rtl/ewc_pkg.sv
package ewc_pkg;

    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_OPEN = 2'd1,
        PG_PROG = 2'd2
    } page_state_e;

endpackage

// File: rtl/ewc_sync.sv
module ewc_sync #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              wr_en_n,
    input  logic              out_en_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              cs_s,
    output logic              we_s,
    output logic              oe_s,
    output logic [ADDR_W-1:0] addr_s,
    output logic [DATA_W-1:0] data_s
);

    // Strobes get a multi-flop synchronizer; the buses ride an equal-depth
    // pipe so each strobe sample lines up with the bus seen at that instant.
    typedef struct packed {
        logic [STAGES-1:0]             cs;
        logic [STAGES-1:0]             we;
        logic [STAGES-1:0]             oe;
        logic [STAGES-1:0][ADDR_W-1:0] a;
        logic [STAGES-1:0][DATA_W-1:0] d;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d      = pipe_q;
        pipe_d.cs[0] = chip_sel_n;
        pipe_d.we[0] = wr_en_n;
        pipe_d.oe[0] = out_en_n;
        pipe_d.a[0]  = addr_i;
        pipe_d.d[0]  = data_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d.cs[i] = pipe_q.cs[i-1];
            pipe_d.we[i] = pipe_q.we[i-1];
            pipe_d.oe[i] = pipe_q.oe[i-1];
            pipe_d.a[i]  = pipe_q.a[i-1];
            pipe_d.d[i]  = pipe_q.d[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q.cs <= '1;
            pipe_q.we <= '1;
            pipe_q.oe <= '1;
            pipe_q.a  <= '0;
            pipe_q.d  <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign cs_s   = pipe_q.cs[STAGES-1];
    assign we_s   = pipe_q.we[STAGES-1];
    assign oe_s   = pipe_q.oe[STAGES-1];
    assign addr_s = pipe_q.a[STAGES-1];
    assign data_s = pipe_q.d[STAGES-1];

endmodule

// File: rtl/ewc_strobe.sv
module ewc_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic we_s,
    input  logic oe_s,
    output logic pulse_start,
    output logic pulse_end,
    output logic we_fall
);

    typedef struct packed {
        logic wp;
        logic we;
    } edge_t;

    edge_t edge_d, edge_q;
    logic  wp_now;

    // Pulse is the AND of both low strobes, gated by a high read enable.
    assign wp_now = ~cs_s & ~we_s & oe_s;

    always_comb begin
        edge_d    = edge_q;
        edge_d.wp = wp_now;
        edge_d.we = we_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q.wp <= 1'b0;
            edge_q.we <= 1'b1;
        end else begin
            edge_q <= edge_d;
        end
    end

    assign pulse_start = wp_now & ~edge_q.wp;
    assign pulse_end   = ~wp_now & edge_q.wp;
    assign we_fall     = edge_q.we & ~we_s;

endmodule

// File: rtl/ewc_page.sv
module ewc_page import ewc_pkg::*; #(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int PAGE_SEL_W = 2,
    parameter int WINDOW_CYC = 64,
    parameter int PROG_CYC   = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_start,
    input  logic              pulse_end,
    input  logic              we_fall,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    output logic              cap_valid,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data,
    output logic              page_err,
    output logic              commit,
    output logic              busy
);

    localparam int PS_W  = (PAGE_SEL_W > 0) ? PAGE_SEL_W : 1;
    localparam int WIN_W = $clog2(WINDOW_CYC + 1);
    localparam int PRG_W = $clog2(PROG_CYC + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_CYC - 1);
    localparam logic [PRG_W-1:0] PRG_LAST = PRG_W'(PROG_CYC - 1);

    typedef struct packed {
        page_state_e       st;
        logic [WIN_W-1:0]  win;
        logic [PRG_W-1:0]  prg;
        logic [PS_W-1:0]   page;
        logic              act;
        logic [ADDR_W-1:0] hold_addr;
        logic              cap_v;
        logic [ADDR_W-1:0] cap_a;
        logic [DATA_W-1:0] cap_d;
        logic              commit;
        logic              err;
    } page_t;

    page_t st_d, st_q;
    logic [PS_W-1:0] sel;
    logic            accept;
    logic            reject;

    // Page-select extraction; a zero-width select disables the check.
    if (PAGE_SEL_W > 0) begin : g_sel
        assign sel = addr_s[ADDR_W-1 -: PAGE_SEL_W];
    end else begin : g_nosel
        assign sel = '0;
    end

    always_comb begin
        st_d        = st_q;
        st_d.cap_v  = 1'b0;
        st_d.commit = 1'b0;
        st_d.err    = 1'b0;

        accept = pulse_start && (st_q.st != PG_PROG)
                 && ((st_q.st == PG_IDLE) || (sel == st_q.page));
        reject = pulse_start && (st_q.st == PG_OPEN) && (sel != st_q.page);

        unique case (st_q.st)
            PG_IDLE: begin
                if (accept) begin
                    st_d.st   = PG_OPEN;
                    st_d.win  = '0;
                    st_d.page = sel;
                end
            end
            PG_OPEN: begin
                if (we_fall || accept) begin
                    st_d.win = '0;
                end else if (st_q.win == WIN_LAST) begin
                    if (!st_q.act) begin
                        st_d.st     = PG_PROG;
                        st_d.prg    = '0;
                        st_d.commit = 1'b1;
                    end
                end else begin
                    st_d.win = st_q.win + 1'b1;
                end
            end
            PG_PROG: begin
                if (st_q.prg == PRG_LAST) begin
                    st_d.st = PG_IDLE;
                end else begin
                    st_d.prg = st_q.prg + 1'b1;
                end
            end
            default: st_d.st = PG_IDLE;
        endcase

        if (accept) begin
            st_d.act       = 1'b1;
            st_d.hold_addr = addr_s;
        end
        if (pulse_end && st_q.act) begin
            st_d.act   = 1'b0;
            st_d.cap_v = 1'b1;
            st_d.cap_a = st_q.hold_addr;
            st_d.cap_d = data_s;
        end
        if (reject) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st        <= PG_IDLE;
            st_q.win       <= '0;
            st_q.prg       <= '0;
            st_q.page      <= '0;
            st_q.act       <= 1'b0;
            st_q.hold_addr <= '0;
            st_q.cap_v     <= 1'b0;
            st_q.cap_a     <= '0;
            st_q.cap_d     <= '0;
            st_q.commit    <= 1'b0;
            st_q.err       <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_valid = st_q.cap_v;
    assign cap_addr  = st_q.cap_a;
    assign cap_data  = st_q.cap_d;
    assign page_err  = st_q.err;
    assign commit    = st_q.commit;
    assign busy      = (st_q.st == PG_PROG);

    // Commit marks the first busy cycle.
    assert_commit_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> busy);
    assert_commit_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
    assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(st_q.prg) == PRG_LAST));
    assert_cap_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> !cap_valid);
    assert_no_cap_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> !busy);
    assert_err_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |=> !page_err);
    assert_err_needs_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |-> ($past(st_q.st) == PG_OPEN));
    assert_no_expire_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(st_q.act));

endmodule

// File: rtl/eeprom_write_capture.sv
module eeprom_write_capture #(
    parameter int ADDR_W      = 19,
    parameter int DATA_W      = 8,
    parameter int PAGE_SEL_W  = 2,
    parameter int SYNC_STAGES = 2,
    parameter int WINDOW_CYC  = 64,
    parameter int PROG_CYC    = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              wr_en_n,
    input  logic              out_en_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              cap_valid,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data,
    output logic              page_err,
    output logic              commit,
    output logic              busy
);

    logic              cs_s, we_s, oe_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic              pulse_start, pulse_end, we_fall;

    ewc_sync #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_sel_n (chip_sel_n),
        .wr_en_n    (wr_en_n),
        .out_en_n   (out_en_n),
        .addr_i     (bus_addr),
        .data_i     (bus_data),
        .cs_s       (cs_s),
        .we_s       (we_s),
        .oe_s       (oe_s),
        .addr_s     (addr_s),
        .data_s     (data_s)
    );

    ewc_strobe u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_s        (cs_s),
        .we_s        (we_s),
        .oe_s        (oe_s),
        .pulse_start (pulse_start),
        .pulse_end   (pulse_end),
        .we_fall     (we_fall)
    );

    ewc_page #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .PAGE_SEL_W (PAGE_SEL_W),
        .WINDOW_CYC (WINDOW_CYC),
        .PROG_CYC   (PROG_CYC)
    ) u_page (
        .clk         (clk),
        .rst_n       (rst_n),
        .pulse_start (pulse_start),
        .pulse_end   (pulse_end),
        .we_fall     (we_fall),
        .addr_s      (addr_s),
        .data_s      (data_s),
        .cap_valid   (cap_valid),
        .cap_addr    (cap_addr),
        .cap_data    (cap_data),
        .page_err    (page_err),
        .commit      (commit),
        .busy        (busy)
    );

    // A pulse start and its end never share a cycle (strobes are level-held).
    assert_start_end_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_start |=> !pulse_end);

endmodule

// File: tb/tb_eeprom_write_capture.sv
`timescale 1ns/1ps
module tb_eeprom_write_capture;

    localparam int AW   = 19;
    localparam int DW   = 8;
    localparam int PSW  = 2;
    localparam int SYNC = 2;
    localparam int WIN  = 64;
    localparam int PRG  = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_sel_n = 1'b1, wr_en_n = 1'b1, out_en_n = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_data = '0;
    logic          cap_valid, page_err, commit, busy;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_data;

    always #2.5 clk = ~clk;

    eeprom_write_capture #(
        .ADDR_W(AW), .DATA_W(DW), .PAGE_SEL_W(PSW),
        .SYNC_STAGES(SYNC), .WINDOW_CYC(WIN), .PROG_CYC(PRG)
    ) dut (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .wr_en_n(wr_en_n),
        .out_en_n(out_en_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .cap_valid(cap_valid), .cap_addr(cap_addr), .cap_data(cap_data),
        .page_err(page_err), .commit(commit), .busy(busy)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    int cap_cnt = 0, err_cnt = 0, commit_cnt = 0, commit_cyc = 0;
    int busy_run = 0, busy_len = -1, commit_nb = 0;
    logic [AW-1:0] cap_a;
    logic [DW-1:0] cap_d;
    int last_start = 0, last_end = 0;

    // Output monitor: samples 1 ns after each rising edge.
    always @(posedge clk) begin
        cyc++;
        #1;
        if (rst_n) begin
            if (cap_valid) begin cap_cnt++; cap_a = cap_addr; cap_d = cap_data; end
            if (page_err) err_cnt++;
            if (commit) begin
                commit_cnt++; commit_cyc = cyc;
                if (!busy) commit_nb++;
            end
            if (busy) busy_run++;
            else if (busy_run != 0) begin busy_len = busy_run; busy_run = 0; end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [PSW-1:0] psel(input logic [AW-1:0] a);
        return a[AW-1 -: PSW];
    endfunction

    // One strobe pair; garbage on the buses outside the sampling points.
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit cs_last, input bit cs_first, input int hold,
                      input bit oe_low);
        @(negedge clk);
        bus_addr = a; bus_data = ~d; out_en_n = !oe_low;
        if (cs_last) begin
            wr_en_n = 1'b0; @(negedge clk); chip_sel_n = 1'b0;
        end else begin
            chip_sel_n = 1'b0; @(negedge clk); wr_en_n = 1'b0;
        end
        last_start = cyc;
        repeat (2) @(negedge clk);
        bus_addr = ~a; bus_data = d;
        repeat (hold) @(negedge clk);
        if (cs_first) chip_sel_n = 1'b1; else wr_en_n = 1'b1;
        last_end = cyc;
        @(negedge clk);
        if (cs_first) wr_en_n = 1'b1; else chip_sel_n = 1'b1;
        @(negedge clk);
        bus_data = ~d; out_en_n = 1'b1;
        repeat (SYNC + 3) @(negedge clk);
    endtask

    task automatic wr_check(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit csl, input bit csf, input int hold);
        int c0 = cap_cnt;
        wr(a, d, csl, csf, hold, 1'b0);
        chk(cap_cnt == c0 + 1, "R5", "capture count", cap_cnt, c0 + 1);
        chk(cap_a == a, "R3", "captured address", cap_a, a);
        chk(cap_d == d, "R4", "captured data", cap_d, d);
    endtask

    task automatic wait_commit(input int cb);
        for (int k = 0; k < WIN + 60 && commit_cnt == cb; k++) @(negedge clk);
        chk(commit_cnt == cb + 1, "R7", "commit count", commit_cnt, cb + 1);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < PRG + 30 && (busy || busy_run != 0); k++) @(negedge clk);
        chk(busy_len == PRG, "R7", "busy length", busy_len, PRG);
        chk(commit_nb == 0, "R7", "commit outside busy", commit_nb, 0);
        busy_len = -1;
    endtask

    task automatic run_page(input logic [PSW-1:0] ps, input int n,
                            input bit inject, input bit poke);
        int cb = commit_cnt;
        int e0, c0;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        for (int i = 0; i < n; i++) begin
            a = {ps, (AW-PSW)'($urandom)};
            d = DW'($urandom);
            wr_check(a, d, 1'($urandom), 1'($urandom), 1 + int'($urandom % 3));
            if (inject && i == 0) begin
                e0 = err_cnt; c0 = cap_cnt;
                a = {ps ^ PSW'(1), (AW-PSW)'($urandom)};
                wr(a, DW'($urandom), 1'b0, 1'($urandom), 1, 1'b0);
                chk(err_cnt == e0 + 1, "R9", "page error on mismatch (R11 page set)", err_cnt, e0 + 1);
                chk(cap_cnt == c0, "R9", "mismatch not captured", cap_cnt, c0);
            end
        end
        wait_commit(cb);
        chk(commit_cyc - last_start == WIN + SYNC + 1, "R6", "window length from last restart",
            commit_cyc - last_start, WIN + SYNC + 1);
        if (poke) begin
            e0 = err_cnt; c0 = cap_cnt;
            wr({~ps, (AW-PSW)'($urandom)}, DW'($urandom), 1'($urandom), 1'($urandom), 1, 1'b0);
            chk(cap_cnt == c0, "R8", "write during busy captured", cap_cnt, c0);
            chk(err_cnt == e0, "R8", "write during busy flagged", err_cnt, e0);
        end
        wait_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int c0, cb;
        void'($urandom(32'h5EED_0A17));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(commit == 1'b0, "R1", "commit after reset", commit, 0);
        chk(cap_valid == 1'b0, "R1", "cap_valid after reset", cap_valid, 0);
        chk(page_err == 1'b0, "R1", "page_err after reset", page_err, 0);

        // All four strobe orderings in one page (R3, R4), page set by first (R11)
        cb = commit_cnt;
        for (int i = 0; i < 4; i++)
            wr_check({2'b01, 17'(i * 5 + 3)}, DW'(8'hA0 + i), i[0], i[1], 2);
        wait_commit(cb);
        chk(commit_cyc - last_start == WIN + SYNC + 1, "R6", "retriggered window",
            commit_cyc - last_start, WIN + SYNC + 1);
        c0 = cap_cnt;
        wr({2'b10, 17'h00055}, 8'h3C, 1'b0, 1'b0, 1, 1'b0);
        chk(cap_cnt == c0, "R8", "write during busy captured", cap_cnt, c0);
        wait_idle();

        // R2: read enable low blocks the pulse and opens no window
        c0 = cap_cnt; cb = commit_cnt;
        wr({2'b11, 17'h1ABCD}, 8'h5A, 1'b1, 1'b0, 2, 1'b1);
        repeat (WIN + 10) @(negedge clk);
        chk(cap_cnt == c0, "R2", "capture with read enable low", cap_cnt, c0);
        chk(commit_cnt == cb, "R2", "window opened with read enable low", commit_cnt, cb);

        // R9/R11: mismatch right after the opening write
        run_page(2'b10, 2, 1'b1, 1'b0);

        // R10: pulse longer than the window
        cb = commit_cnt;
        wr_check({2'b00, 17'h0F0F0}, 8'hE7, 1'b1, 1'b1, WIN + 20);
        wait_commit(cb);
        chk(commit_cyc - last_end == SYNC + 2, "R10", "expiry held until pulse end",
            commit_cyc - last_end, SYNC + 2);
        wait_idle();

        // Random pages
        for (int p = 0; p < 12; p++)
            run_page(PSW'($urandom), 1 + int'($urandom % 4), 1'($urandom % 3 == 0),
                     1'($urandom));

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule